// File: doc/BRIEF.md
# Dual-Ratio Oversampling UART Receiver

This block is the receive engine of a serial port. It sits behind a baud-rate enable (`tick_en`) that pulses either 16 or 13 times per bit period, the ratio being picked by `os13_sel`. The serial input is first brought into the clock domain by a two-flop synchroniser. A falling edge of the synchronised line, seen on a tick, starts the frame. From that tick on, ticks are counted, and one sample is taken per bit period at a fixed tick: the 8th at 16x and the 6th at 13x.

Each frame is made of a start bit, 5 to 8 data bits sent LSB first, an optional even or odd parity bit, and one or two stop bits. Every bit is sampled by the same rule. When the last stop bit has been sampled, the block gives the byte with a one-cycle valid pulse. Framing, parity and break flags are aligned with that pulse. The engine then waits for the next start edge at once, so frames with no idle gap between them are accepted. Frame format inputs are captured when the start edge is detected and must stay steady until the valid pulse.

Top module: `uart_os_rx`

## Requirements
- R1: With `os13_sel`=0, bit k of a frame (start bit = 0) is sampled on tick number 16*k+8, counting the detection tick as tick 0.
- R2: With `os13_sel`=1, bit k of a frame is sampled on tick number 13*k+6, counting the detection tick as tick 0.
- R3: `rxd` passes through two flip-flops before use. A frame starts on the tick where the synchronised line is low and was high on the previous tick, and the tick count restarts from that tick.
- R4: If the start bit samples high, no output is produced and the engine goes back to waiting for a falling edge.
- R5: `word_len` codes 0,1,2,3 select 5,6,7,8 data bits. The first data bit received lands in `rx_data[0]`, and bits above the data length read 0.
- R6: With `parity_on`=1 a parity bit follows the data. `parity_odd`=0 requires an even number of ones across data and parity; `parity_odd`=1 requires an odd number. A mismatch sets `parity_err`. With `parity_on`=0, `parity_err` stays 0.
- R7: `two_stops`=0 gives one stop bit and `two_stops`=1 gives two. `frame_err` is set when any stop-bit sample is low.
- R8: `break_det` is set, together with `frame_err`, when every sampled bit of the frame (start, data, parity, stops) is low. A frame of zero data with a high stop bit does not set it.
- R9: `rx_valid` is high for exactly one clock per received frame, in the clock after the last stop-bit sample. The three flags are 0 whenever `rx_valid` is 0.
- R10: A new start edge is accepted on any tick after the last stop-bit sample, so frames sent with no idle time between them are all received.
- R11: A frame of start, 8 data bits and one stop bit is received correctly when its bit period is between 4% shorter and 5% longer than nominal, in either ratio.
- R12: While `rst_n` is low, `rx_valid`, `rx_data` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Oversampling tick enable, 13 or 16 per bit period |
| os13_sel | input | 1 | 1: 13 ticks per bit, 0: 16 ticks per bit |
| word_len | input | 2 | Data length code, 0..3 for 5..8 bits |
| parity_on | input | 1 | A parity bit follows the data |
| parity_odd | input | 1 | 1: odd parity, 0: even parity |
| two_stops | input | 1 | 1: two stop bits, 0: one |
| rxd | input | 1 | Asynchronous serial input, idle high |
| rx_data | output | 8 | Received data, right aligned |
| rx_valid | output | 1 | One-cycle strobe for a completed frame |
| frame_err | output | 1 | Stop bit sampled low |
| parity_err | output | 1 | Parity mismatch |
| break_det | output | 1 | Whole frame sampled low |

## Verification
If the tick counter is off by one, the sample point moves by a whole tick. The bench drives data bits that hold their value only within a few clocks of the correct sample point, so such an error gives a wrong `rx_data` bit at that frame's valid pulse, about one frame time after the start edge. A frame-state or bit-index fault shows up as a missing or extra `rx_valid` pulse by the end of that frame. A parity or break accumulator fault shows up in the flags at the same pulse. An edge detector that re-arms wrongly fires a stray frame no more than one frame later, while the line is held low or during a glitch.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;

  localparam int unsigned OS_WIDE    = 16;
  localparam int unsigned OS_NARROW  = 13;
  localparam int unsigned MID_WIDE   = 8;
  localparam int unsigned MID_NARROW = 6;
  localparam int unsigned OS_CNT_W   = $clog2(OS_WIDE);

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  typedef struct packed {
    logic       narrow;
    logic [1:0] len_code;
    logic       par_on;
    logic       par_odd;
    logic       two_stop;
  } rx_cfg_t;

endpackage

// File: rtl/uart_os_rx_sync.sv
module uart_os_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_d;

  always_comb begin
    ff_d = {ff_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_q <= '1;
    end else begin
      ff_q <= ff_d;
    end
  end

  assign q = ff_q[STAGES-1];

endmodule

// File: rtl/uart_os_rx_tick.sv
module uart_os_rx_tick
  import uart_os_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic restart,
  input  logic narrow,
  output logic samp_now
);

  localparam logic [OS_CNT_W-1:0] LAST_W = OS_CNT_W'(OS_WIDE - 1);
  localparam logic [OS_CNT_W-1:0] LAST_N = OS_CNT_W'(OS_NARROW - 1);
  localparam logic [OS_CNT_W-1:0] MID_W  = OS_CNT_W'(MID_WIDE - 1);
  localparam logic [OS_CNT_W-1:0] MID_N  = OS_CNT_W'(MID_NARROW - 1);

  logic [OS_CNT_W-1:0] cnt_q;
  logic [OS_CNT_W-1:0] cnt_d;
  logic [OS_CNT_W-1:0] last_val;
  logic [OS_CNT_W-1:0] mid_val;

  always_comb begin
    last_val = narrow ? LAST_N : LAST_W;
    mid_val  = narrow ? MID_N : MID_W;
    cnt_d    = cnt_q;
    if (restart) begin
      cnt_d = '0;
    end else if (tick_en) begin
      cnt_d = (cnt_q == last_val) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign samp_now = tick_en && (cnt_q == mid_val);

endmodule

// File: rtl/uart_os_rx_frame.sv
module uart_os_rx_frame
  import uart_os_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              line_s,
  input  logic              samp_now,
  input  rx_cfg_t           cfg_in,
  output logic              restart,
  output rx_cfg_t           cfg_q,
  output logic [DATA_W-1:0] data_q,
  output logic              valid_q,
  output logic              fe_q,
  output logic              pe_q,
  output logic              bk_q
);

  localparam int unsigned IDX_W = $clog2(DATA_W);

  rx_state_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic              ones_q, ones_d;
  logic              seen_q, seen_d;
  logic              ferr_q, ferr_d;
  logic              prev_q, prev_d;
  rx_cfg_t           cfg_d;
  logic [DATA_W-1:0] data_d;
  logic              valid_d, fe_d, pe_d, bk_d;
  logic [IDX_W-1:0]  last_idx;
  logic              stop_ferr, stop_seen;

  always_comb begin
    last_idx  = IDX_W'(DATA_W - 4) + IDX_W'(cfg_q.len_code);
    stop_ferr = ferr_q | ~line_s;
    stop_seen = seen_q | line_s;

    state_d = state_q;
    idx_d   = idx_q;
    shreg_d = shreg_q;
    ones_d  = ones_q;
    seen_d  = seen_q;
    ferr_d  = ferr_q;
    cfg_d   = cfg_q;
    prev_d  = tick_en ? line_s : prev_q;
    restart = 1'b0;
    data_d  = data_q;
    valid_d = 1'b0;
    fe_d    = 1'b0;
    pe_d    = 1'b0;
    bk_d    = 1'b0;

    case (state_q)
      RX_IDLE: begin
        if (tick_en && prev_q && !line_s) begin
          restart = 1'b1;
          cfg_d   = cfg_in;
          state_d = RX_START;
          idx_d   = '0;
          shreg_d = '0;
          ones_d  = 1'b0;
          seen_d  = 1'b0;
          ferr_d  = 1'b0;
        end
      end
      RX_START: begin
        if (samp_now) begin
          state_d = line_s ? RX_IDLE : RX_DATA;
        end
      end
      RX_DATA: begin
        if (samp_now) begin
          shreg_d[idx_q] = line_s;
          ones_d = ones_q ^ line_s;
          seen_d = stop_seen;
          if (idx_q == last_idx) begin
            idx_d   = '0;
            state_d = cfg_q.par_on ? RX_PAR : RX_STOP;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      RX_PAR: begin
        if (samp_now) begin
          ones_d  = ones_q ^ line_s;
          seen_d  = stop_seen;
          state_d = RX_STOP;
        end
      end
      RX_STOP: begin
        if (samp_now) begin
          if (cfg_q.two_stop && (idx_q == '0)) begin
            idx_d  = idx_q + 1'b1;
            ferr_d = stop_ferr;
            seen_d = stop_seen;
          end else begin
            valid_d = 1'b1;
            data_d  = shreg_q;
            fe_d    = stop_ferr;
            pe_d    = cfg_q.par_on & (ones_q ^ cfg_q.par_odd);
            bk_d    = ~stop_seen;
            state_d = RX_IDLE;
          end
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      idx_q   <= '0;
      shreg_q <= '0;
      ones_q  <= 1'b0;
      seen_q  <= 1'b0;
      ferr_q  <= 1'b0;
      prev_q  <= 1'b1;
      cfg_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      fe_q    <= 1'b0;
      pe_q    <= 1'b0;
      bk_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      shreg_q <= shreg_d;
      ones_q  <= ones_d;
      seen_q  <= seen_d;
      ferr_q  <= ferr_d;
      prev_q  <= prev_d;
      cfg_q   <= cfg_d;
      data_q  <= data_d;
      valid_q <= valid_d;
      fe_q    <= fe_d;
      pe_q    <= pe_d;
      bk_q    <= bk_d;
    end
  end

endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
  import uart_os_rx_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              os13_sel,
  input  logic [1:0]        word_len,
  input  logic              parity_on,
  input  logic              parity_odd,
  input  logic              two_stops,
  input  logic              rxd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              frame_err,
  output logic              parity_err,
  output logic              break_det
);

  logic    line_s;
  logic    restart;
  logic    samp_now;
  rx_cfg_t cfg_in;
  rx_cfg_t cfg_q;

  always_comb begin
    cfg_in.narrow   = os13_sel;
    cfg_in.len_code = word_len;
    cfg_in.par_on   = parity_on;
    cfg_in.par_odd  = parity_odd;
    cfg_in.two_stop = two_stops;
  end

  uart_os_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rxd),
    .q     (line_s)
  );

  uart_os_rx_tick u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .restart  (restart),
    .narrow   (cfg_q.narrow),
    .samp_now (samp_now)
  );

  uart_os_rx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .line_s   (line_s),
    .samp_now (samp_now),
    .cfg_in   (cfg_in),
    .restart  (restart),
    .cfg_q    (cfg_q),
    .data_q   (rx_data),
    .valid_q  (rx_valid),
    .fe_q     (frame_err),
    .pe_q     (parity_err),
    .bk_q     (break_det)
  );

endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic [1:0]        word_len,
  input logic              parity_on,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              frame_err,
  input logic              parity_err,
  input logic              break_det
);

  p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_flags_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> !(frame_err || parity_err || break_det));

  p_valid_after_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(tick_en));

  p_break_framing_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && break_det) |-> (frame_err && (rx_data == '0)));

  p_no_parity_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !parity_on) |-> !parity_err);

  p_upper_bits_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((rx_data >> (32'(word_len) + 32'd5)) == '0));

endmodule

bind uart_os_rx uart_os_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en    (tick_en),
  .word_len   (word_len),
  .parity_on  (parity_on),
  .rx_data    (rx_data),
  .rx_valid   (rx_valid),
  .frame_err  (frame_err),
  .parity_err (parity_err),
  .break_det  (break_det)
);

// File: tb/uart_os_rx_tb.sv
`timescale 1ns/1ps
module uart_os_rx_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] phase = 2'd0;
  logic       tick_en;
  logic       os13_sel = 1'b0;
  logic [1:0] word_len = 2'd3;
  logic       parity_on = 1'b0;
  logic       parity_odd = 1'b0;
  logic       two_stops = 1'b0;
  logic       rxd = 1'b1;
  logic [7:0] rx_data;
  logic       rx_valid, frame_err, parity_err, break_det;

  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  string cur_req = "R12";

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= 2'd0;
    else        phase <= phase + 2'd1;
  end
  assign tick_en = rst_n && (phase == 2'd0);

  uart_os_rx u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .os13_sel(os13_sel),
    .word_len(word_len), .parity_on(parity_on), .parity_odd(parity_odd),
    .two_stops(two_stops), .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
    .frame_err(frame_err), .parity_err(parity_err), .break_det(break_det)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: ticks counted from detection, samples in a queue.
  bit   m_s1 = 1, m_s2 = 1, m_prev = 1, m_busy = 0;
  int   m_cnt, m_n, m_mid, m_len, m_total;
  bit   m_par, m_odd;
  bit   m_q[$];
  bit   e_valid = 0, e_fe = 0, e_pe = 0, e_bk = 0;
  int   e_data = 0;

  always @(posedge clk) begin
    bit s;
    e_valid = 0;
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_prev = 1; m_busy = 0; m_q.delete();
    end else begin
      s = m_s2;
      if (tick_en) begin
        if (!m_busy) begin
          if (m_prev && !s) begin
            m_busy = 1; m_cnt = 0; m_q.delete();
            m_n   = os13_sel ? 13 : 16;
            m_mid = os13_sel ? 6 : 8;
            m_len = 5 + int'(word_len);
            m_par = parity_on; m_odd = parity_odd;
            m_total = 2 + m_len + int'(parity_on) + int'(two_stops);
          end
        end else begin
          m_cnt++;
          if ((m_cnt % m_n) == m_mid) begin
            m_q.push_back(s);
            if (m_q.size() == 1 && s) begin
              m_busy = 0;
            end else if (m_q.size() == m_total) begin
              bit ones, anyhi, fe;
              int d;
              ones = 0; anyhi = 0; fe = 0; d = 0;
              foreach (m_q[i]) anyhi |= m_q[i];
              for (int i = 0; i < m_len; i++) begin
                if (m_q[1+i]) d |= (1 << i);
                ones ^= m_q[1+i];
              end
              if (m_par) ones ^= m_q[1+m_len];
              for (int i = 1 + m_len + int'(m_par); i < m_total; i++)
                if (!m_q[i]) fe = 1;
              e_valid = 1; e_data = d; e_fe = fe;
              e_pe = m_par && (ones ^ m_odd); e_bk = !anyhi;
              m_busy = 0;
            end
          end
        end
        m_prev = s;
      end
      m_s2 = m_s1; m_s1 = rxd;
    end
  end

  int   nrx = 0;
  logic [7:0] last_data;
  bit   last_fe, last_pe, last_bk;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, "valid vs model", int'(rx_valid), int'(e_valid));
      if (e_valid) begin
        check(cur_req, "data vs model", int'(rx_data), e_data);
        check(cur_req, "frame_err vs model", int'(frame_err), int'(e_fe));
        check(cur_req, "parity_err vs model", int'(parity_err), int'(e_pe));
        check(cur_req, "break vs model", int'(break_det), int'(e_bk));
      end else begin
        check("R9", "flags quiet without valid", int'(frame_err | parity_err | break_det), 0);
      end
      if (rx_valid) begin
        nrx++; last_data = rx_data;
        last_fe = frame_err; last_pe = parity_err; last_bk = break_det;
      end
    end
  end

  task automatic align();
    @(negedge clk);
    while (phase != 2'd1) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop,
                            input int per_x100, input bit win, input int gap);
    bit b[16];
    int n, dl, ctr, nom, tot;
    bit ones;
    dl = 5 + int'(word_len);
    n = 0; ones = 0;
    b[n] = 0; n++;
    for (int i = 0; i < dl; i++) begin b[n] = d[i]; ones ^= d[i]; n++; end
    if (parity_on) begin b[n] = ones ^ parity_odd ^ bad_par; n++; end
    if (two_stops) begin b[n] = 1; n++; end
    b[n] = !bad_stop; n++;
    nom = os13_sel ? 52 : 64;
    ctr = os13_sel ? 25 : 33;
    tot = (n * per_x100) / 100;
    align();
    for (int t = 0; t < tot; t++) begin
      int k, off;
      bit v;
      k = (t * 100) / per_x100;
      v = b[k];
      if (win && k >= 1 && k <= dl) begin
        off = t - k * nom;
        if (off < ctr - 2 || off > ctr + 2) v = !v;
      end
      rxd = v;
      @(negedge clk);
    end
    rxd = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  task automatic expect_rx(input string req, input int n_before, input logic [7:0] d,
                           input bit fe, input bit pe, input bit bk);
    logic [7:0] mask;
    mask = 8'((1 << (5 + int'(word_len))) - 1);
    check({req, " R9"}, "one valid per frame", nrx - n_before, 1);
    check(req, "data", int'(last_data), int'(d & mask));
    check(req, "frame_err", int'(last_fe), int'(fe));
    check(req, "parity_err", int'(last_pe), int'(pe));
    check(req, "break", int'(last_bk), int'(bk));
  endtask

  task automatic set_cfg(input bit m13, input int len, input bit pon, input bit podd, input bit two);
    os13_sel = m13; word_len = 2'(len - 5); parity_on = pon; parity_odd = podd; two_stops = two;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired in %s", cur_req);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    logic [7:0] pats [4];
    int nb;
    pats[0] = 8'hA5; pats[1] = 8'h3C; pats[2] = 8'h01; pats[3] = 8'hFE;

    repeat (4) @(negedge clk);
    check("R12", "valid in reset", int'(rx_valid), 0);
    check("R12", "data in reset", int'(rx_data), 0);
    check("R12", "flags in reset", int'(frame_err | parity_err | break_det), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    cur_req = "R1 R3";
    set_cfg(0, 8, 0, 0, 0);
    foreach (pats[i]) begin
      nb = nrx; send_frame(pats[i], 0, 0, 6400, 1, 16); expect_rx("R1 R3", nb, pats[i], 0, 0, 0);
    end

    cur_req = "R2";
    set_cfg(1, 8, 0, 0, 0);
    foreach (pats[i]) begin
      nb = nrx; send_frame(pats[i], 0, 0, 5200, 1, 16); expect_rx("R2", nb, pats[i], 0, 0, 0);
    end

    cur_req = "R5 R6";
    for (int len = 5; len <= 8; len++) begin
      set_cfg(len[0], len, 1, len[1], 0);
      nb = nrx; send_frame(8'hB7, 0, 0, len[0] ? 5200 : 6400, 0, 20);
      expect_rx("R5 R6", nb, 8'hB7, 0, 0, 0);
    end

    cur_req = "R6";
    set_cfg(0, 7, 1, 0, 0);
    nb = nrx; send_frame(8'h5A, 1, 0, 6400, 0, 20); expect_rx("R6", nb, 8'h5A, 0, 1, 0);
    set_cfg(1, 8, 1, 1, 0);
    nb = nrx; send_frame(8'h81, 1, 0, 5200, 0, 20); expect_rx("R6", nb, 8'h81, 0, 1, 0);

    cur_req = "R7";
    set_cfg(0, 8, 0, 0, 1);
    nb = nrx; send_frame(8'h69, 0, 0, 6400, 0, 20); expect_rx("R7", nb, 8'h69, 0, 0, 0);
    nb = nrx; send_frame(8'h96, 0, 1, 6400, 0, 20); expect_rx("R7", nb, 8'h96, 1, 0, 0);
    set_cfg(1, 6, 1, 0, 0);
    nb = nrx; send_frame(8'h2D, 0, 1, 5200, 0, 20); expect_rx("R7", nb, 8'h2D, 1, 0, 0);

    cur_req = "R8";
    set_cfg(0, 8, 0, 0, 0);
    nb = nrx; send_frame(8'h00, 0, 0, 6400, 0, 20); expect_rx("R8", nb, 8'h00, 0, 0, 0);
    nb = nrx;
    align();
    rxd = 1'b0;
    repeat (12 * 64) @(negedge clk);
    rxd = 1'b1;
    repeat (40) @(negedge clk);
    expect_rx("R8", nb, 8'h00, 1, 0, 1);

    cur_req = "R4";
    nb = nrx;
    align();
    rxd = 1'b0;
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    repeat (900) @(negedge clk);
    check("R4", "no frame from glitch", nrx - nb, 0);
    nb = nrx; send_frame(8'hC3, 0, 0, 6400, 0, 20); expect_rx("R4", nb, 8'hC3, 0, 0, 0);

    cur_req = "R10";
    set_cfg(1, 8, 1, 0, 0);
    foreach (pats[i]) begin
      nb = nrx; send_frame(pats[i], 0, 0, 5200, 0, 0); expect_rx("R10", nb, pats[i], 0, 0, 0);
    end
    repeat (30) @(negedge clk);

    cur_req = "R11";
    set_cfg(0, 8, 0, 0, 0);
    nb = nrx; send_frame(8'h4B, 0, 0, 6144, 0, 20); expect_rx("R11", nb, 8'h4B, 0, 0, 0);
    nb = nrx; send_frame(8'hD2, 0, 0, 6720, 0, 20); expect_rx("R11", nb, 8'hD2, 0, 0, 0);
    set_cfg(1, 8, 0, 0, 0);
    nb = nrx; send_frame(8'h4B, 0, 0, 4992, 0, 20); expect_rx("R11", nb, 8'h4B, 0, 0, 0);
    nb = nrx; send_frame(8'hD2, 0, 0, 5460, 0, 20); expect_rx("R11", nb, 8'hD2, 0, 0, 0);

    repeat (20) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule